// File: doc/BRIEF.md
# Serial audio clock and frame-sync generator

This block produces the bit clock and the frame sync of a serial audio link from a faster master clock. It can also follow a bit clock and a frame sync that arrive from outside. Two settings choose where each clock comes from, and they are independent of each other. The bit clock can be made locally or taken from the external pin. The frame sync can be made locally or taken from its own external pin.

Static configuration inputs set the following:
- the frame period, either directly or derived from a frame size in bits;
- the sync pulse length, held in a four-bit low part plus an extension part;
- the data format, which decides the sync polarity and the pulse shape.

A write port loads the master-clock divider. Transmit and receive share this one divider. While both directions are active, a write that would change an already-set divider is refused.

The block has three outputs:
- the bit clock, with its output enable;
- the frame sync, with its output enable;
- a frame-start strobe, one master-clock cycle long, which tells the data shifters where a frame begins.

Top module: `audio_sync_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `bclk_o` and `frame_start` are 0, `fsync_o` sits at the idle level of the selected format, and the divider is cleared. With the cleared divider, `bclk_o` stays low until a divider is written.
- R2: With `bclk_local`=1 and a divider D>0, `bclk_o` holds each level for exactly D master-clock cycles, so its period is 2*D cycles.
- R3: A divider of 0 holds `bclk_o` low with no edges.
- R4: The divider write `div_wr` is refused only when all three of these hold: `tx_active`=1 and `rx_active`=1, the stored divider is nonzero, and `div_wr_val` differs from it. A refused write raises `div_reject` for one cycle, on the cycle after the write, and leaves the divider unchanged. Every other write loads the divider.
- R5: With `fsync_local`=1 and `auto_period`=0, a frame lasts 2*(`period`+1) bit clocks. The sync pulse begins at the first bit-clock rising edge of each frame.
- R6: With `auto_period`=1 and an even `frame_bits` of at least 2, a frame lasts `frame_bits` bit clocks. This is the same as setting the period field to `frame_bits`/2-1.
- R7: Outside the DSP-A format, the sync pulse lasts L+1 bit clocks, where L = `slen_ext`*16 + `slen_lo`.
- R8: The `fmt` encoding is 0 = left-justified, 1 = I2S, 2 = DSP-A, and 3 behaves as 0. In I2S the sync is active low and idles high. In every other format it is active high and idles low.
- R9: In DSP-A (`fmt`=2) the sync pulse lasts exactly one bit clock, whatever the pulse-length fields hold.
- R10: With `fsync_local`=0, `fsync_o` and `fsync_oe` are 0. `frame_start` pulses once for each active edge of `ext_fsync`: a falling edge for I2S, a rising edge for the other formats.
- R11: With `bclk_local`=0, `bclk_o` and `bclk_oe` are 0. The frame counter advances on the rising edges of `ext_bclk`, so a frame lasts 2*(`period`+1) external bit-clock periods.
- R12: `frame_start` is a single-cycle pulse. With a local frame clock it coincides with the first cycle in which `fsync_o` shows the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| div_wr | input | 1 | Divider write request |
| div_wr_val | input | DIV_W | Divider value to write |
| tx_active | input | 1 | Transmit direction in use |
| rx_active | input | 1 | Receive direction in use |
| div_reject | output | 1 | Pulse: last divider write refused |
| fmt | input | 2 | Format: 0 left-justified, 1 I2S, 2 DSP-A |
| bclk_local | input | 1 | 1: bit clock generated here |
| fsync_local | input | 1 | 1: frame sync generated here |
| period | input | PER_W | Frame period field |
| auto_period | input | 1 | 1: derive period from frame_bits |
| frame_bits | input | PER_W+2 | Frame size in bits (even) |
| slen_lo | input | 4 | Sync length, low part |
| slen_ext | input | SLEN_EXT_W | Sync length, extension part |
| ext_bclk | input | 1 | External bit clock |
| ext_fsync | input | 1 | External frame sync |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit clock output enable |
| fsync_o | output | 1 | Generated frame sync |
| fsync_oe | output | 1 | Frame sync output enable |
| frame_start | output | 1 | One-cycle frame-start strobe |

## Verification
`div_reject` is due one clock edge after the edge that samples `div_wr`. A local bit-clock level changes every D edges. `fsync_o` and `frame_start` change on the same edge as the `bclk_o` rise that starts a bit. An external sync edge reaches `frame_start` two edges after the edge that first captures it. An external bit-clock rise moves `fsync_o` three edges after capture. A behavioural model advances on each rising edge with the same input values the design saw, and it is compared with every output at the falling edge, so each of these latencies is checked exactly. Directed measurements of frame gaps, pulse lengths and bit-clock levels count falling-edge samples, and inputs change only one time unit after a rising edge.

// File: rtl/audio_sync_gen.sv
module audio_sync_gen #(
  parameter int DIV_W      = 12,
  parameter int PER_W      = 8,
  parameter int SLEN_EXT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  div_wr,
  input  logic [DIV_W-1:0]      div_wr_val,
  input  logic                  tx_active,
  input  logic                  rx_active,
  output logic                  div_reject,
  input  logic [1:0]            fmt,
  input  logic                  bclk_local,
  input  logic                  fsync_local,
  input  logic [PER_W-1:0]      period,
  input  logic                  auto_period,
  input  logic [PER_W+1:0]      frame_bits,
  input  logic [3:0]            slen_lo,
  input  logic [SLEN_EXT_W-1:0] slen_ext,
  input  logic                  ext_bclk,
  input  logic                  ext_fsync,
  output logic                  bclk_o,
  output logic                  bclk_oe,
  output logic                  fsync_o,
  output logic                  fsync_oe,
  output logic                  frame_start
);
  localparam logic [1:0] FMT_I2S  = 2'd1;
  localparam logic [1:0] FMT_DSPA = 2'd2;
  localparam int CNT_W  = PER_W + 2;
  localparam int SLEN_W = SLEN_EXT_W + 4;

  logic [DIV_W-1:0]  div_q, hcnt;
  logic              bclk_q;
  logic [2:0]        bsync, fsync_s;
  logic [CNT_W-1:0]  fcnt, fnext, flen_m1;
  logic [PER_W:0]    half_bits;
  logic [PER_W-1:0]  per_eff;
  logic [SLEN_W-1:0] slen;
  logic              run, sync_act, sync_prev;
  logic              clash, half_done, bit_rise, neg, ext_edge;

  // shared divider
  assign clash = tx_active & rx_active & (div_q != '0) & (div_wr_val != div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q      <= '0;
      div_reject <= 1'b0;
    end else begin
      div_reject <= div_wr & clash;
      if (div_wr & ~clash) div_q <= div_wr_val;
    end
  end

  // bit clock
  assign half_done = (div_q != '0) && (hcnt >= div_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || div_q == '0) begin
      hcnt   <= '0;
      bclk_q <= 1'b0;
    end else if (half_done) begin
      hcnt   <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      hcnt   <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bsync   <= '0;
      fsync_s <= '0;
    end else begin
      bsync   <= {bsync[1:0], ext_bclk};
      fsync_s <= {fsync_s[1:0], ext_fsync};
    end
  end

  assign bit_rise = bclk_local ? (half_done & ~bclk_q) : (bsync[1] & ~bsync[2]);

  // frame counter
  assign half_bits = frame_bits[PER_W+1:1];
  assign per_eff   = auto_period ? PER_W'(half_bits - 1'b1) : period;
  assign flen_m1   = {1'b0, per_eff, 1'b1};
  assign fnext     = (!run || fcnt >= flen_m1) ? '0 : fcnt + 1'b1;
  assign slen      = {slen_ext, slen_lo};

  always_ff @(posedge clk) begin
    if (rst || !fsync_local) begin
      fcnt     <= '0;
      run      <= 1'b0;
      sync_act <= 1'b0;
    end else if (bit_rise) begin
      fcnt     <= fnext;
      run      <= 1'b1;
      sync_act <= (fmt == FMT_DSPA) ? (fnext == '0) : (32'(fnext) <= 32'(slen));
    end
  end

  always_ff @(posedge clk) sync_prev <= rst ? 1'b0 : sync_act;

  // outputs
  assign neg      = (fmt == FMT_I2S);
  assign ext_edge = neg ? (~fsync_s[1] & fsync_s[2]) : (fsync_s[1] & ~fsync_s[2]);

  assign bclk_oe     = bclk_local;
  assign bclk_o      = bclk_local & bclk_q;
  assign fsync_oe    = fsync_local;
  assign fsync_o     = fsync_local & (sync_act ^ neg);
  assign frame_start = fsync_local ? (sync_act & ~sync_prev) : ext_edge;
endmodule

// File: rtl/audio_sync_gen_chk.sv
module audio_sync_gen_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] div_q,
  input logic          div_reject,
  input logic          bclk_local,
  input logic          bclk_o,
  input logic          fsync_local,
  input logic          fsync_o,
  input logic [1:0]    fmt,
  input logic          frame_start
);
  // R3
  div_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bclk_local && div_q == '0) |=> !bclk_o);

  // R4
  reject_keeps_div_chk: assert property (@(posedge clk) disable iff (rst)
    div_reject |-> $stable(div_q));

  // R8
  start_at_active_level_chk: assert property (@(posedge clk) disable iff (rst)
    (fsync_local && frame_start) |-> (fsync_o == (fmt != 2'd1)));

  // R12
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && fsync_local) |=> (!frame_start || !fsync_local));
endmodule

bind audio_sync_gen audio_sync_gen_chk #(.DW(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .div_q(div_q), .div_reject(div_reject),
  .bclk_local(bclk_local), .bclk_o(bclk_o), .fsync_local(fsync_local),
  .fsync_o(fsync_o), .fmt(fmt), .frame_start(frame_start)
);

// File: tb/tb_audio_sync_gen.sv
module tb_audio_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12, PW = 8, SEW = 2;
  localparam int WATCHDOG = 150000;
  localparam int EB_HALF = 5;

  logic clk = 0, rst = 1;
  logic div_wr = 0; logic [DW-1:0] div_wr_val = '0;
  logic tx_active = 0, rx_active = 0, div_reject;
  logic [1:0] fmt = 2'd0;
  logic bclk_local = 1, fsync_local = 0;
  logic [PW-1:0] period = '0; logic auto_period = 0; logic [PW+1:0] frame_bits = '0;
  logic [3:0] slen_lo = '0; logic [SEW-1:0] slen_ext = '0;
  logic ext_bclk = 0, ext_fsync = 0;
  logic bclk_o, bclk_oe, fsync_o, fsync_oe, frame_start;

  audio_sync_gen #(.DIV_W(DW), .PER_W(PW), .SLEN_EXT_W(SEW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  int mdiv = 0, hc = 0, fc = 0;
  bit mb = 0, mrun = 0, mact = 0, mprev = 0, mrej = 0;
  bit es1 = 0, es2 = 0, es3 = 0, fs1 = 0, fs2 = 0, fs3 = 0;

  always @(posedge clk) begin
    bit rise; int lm1;
    if (rst) begin
      mdiv = 0; hc = 0; fc = 0; mb = 0; mrun = 0; mact = 0; mprev = 0; mrej = 0;
      es1 = 0; es2 = 0; es3 = 0; fs1 = 0; fs2 = 0; fs3 = 0;
    end else begin
      rise = bclk_local ? (mdiv != 0 && hc >= mdiv - 1 && !mb) : (es2 && !es3);
      mprev = mact;
      if (mdiv == 0) begin hc = 0; mb = 0; end
      else if (hc >= mdiv - 1) begin hc = 0; mb = !mb; end
      else hc++;
      if (!fsync_local) begin fc = 0; mrun = 0; mact = 0; end
      else if (rise) begin
        lm1 = auto_period ? int'(frame_bits) - 1 : 2 * int'(period) + 1;
        if (!mrun || fc >= lm1) fc = 0; else fc++;
        mrun = 1;
        mact = (fmt == 2'd2) ? (fc == 0) : (fc <= int'(slen_ext) * 16 + int'(slen_lo));
      end
      es3 = es2; es2 = es1; es1 = ext_bclk;
      fs3 = fs2; fs2 = fs1; fs1 = ext_fsync;
      mrej = 0;
      if (div_wr) begin
        if (tx_active && rx_active && mdiv != 0 && int'(div_wr_val) != mdiv) mrej = 1;
        else mdiv = int'(div_wr_val);
      end
    end
  end

  task automatic cmp(string nm, logic a, logic e);
    vectors++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s got %0b exp %0b at %0t", cur_req, nm, a, e, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("bclk_o", bclk_o, bclk_local ? mb : 1'b0);
    cmp("bclk_oe", bclk_oe, bclk_local);
    cmp("fsync_o", fsync_o, fsync_local ? (mact ^ (fmt == 2'd1)) : 1'b0);
    cmp("fsync_oe", fsync_oe, fsync_local);
    cmp("frame_start", frame_start, fsync_local ? (mact && !mprev)
        : ((fmt == 2'd1) ? (!fs2 && fs3) : (fs2 && !fs3)));
    cmp("div_reject", div_reject, mrej);
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
    end
  end

  int eb_cnt = 0; bit eb_on = 0;
  always @(posedge clk) begin
    #1;
    if (eb_on) begin
      if (eb_cnt == EB_HALF - 1) begin eb_cnt = 0; ext_bclk = ~ext_bclk; end
      else eb_cnt++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_div(int v);
    div_wr = 1; div_wr_val = DW'(v);
    cyc(1);
    div_wr = 0;
  endtask

  task automatic wait_start();
    int g = 0;
    @(negedge clk);
    while (!frame_start && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic start_gap(output int n);
    wait_start(); wait_start();
    n = 1; @(negedge clk);
    while (!frame_start && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic active_len(logic lvl, output int n);
    wait_start(); wait_start();
    n = 0;
    while (fsync_o == lvl && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic high_len(output int n);
    int g = 0;
    @(negedge clk);
    while (bclk_o && g < 5000) begin @(negedge clk); g++; end
    while (!bclk_o && g < 5000) begin @(negedge clk); g++; end
    n = 0;
    while (bclk_o && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic count_ones_bclk(int n, output int k);
    k = 0;
    repeat (n) begin @(negedge clk); if (bclk_o) k++; end
  endtask

  initial begin
    int n;
    cur_req = "R1";
    cyc(3);
    @(negedge clk);
    check("R1 bclk_o in reset", bclk_o, 0);
    check("R1 fsync_o idle in reset", fsync_o, 0);
    check("R1 frame_start in reset", frame_start, 0);
    rst = 0;
    cyc(1);
    check("R1 div_reject after reset", div_reject, 0);
    cur_req = "R3";
    count_ones_bclk(40, n);
    check("R3 bclk silent with cleared divider", n, 0);

    cur_req = "R2";
    write_div(3);
    high_len(n);
    check("R2 bclk high length div=3", n, 3);
    high_len(n);
    check("R2 bclk second high length div=3", n, 3);

    cur_req = "R4";
    tx_active = 1; rx_active = 1;
    cyc(1);
    write_div(5);
    check("R4 differing write refused", div_reject, 1);
    cyc(1);
    check("R4 reject lasts one cycle", div_reject, 0);
    high_len(n);
    check("R4 divider kept after refusal", n, 3);
    cyc(1);
    write_div(3);
    check("R4 equal write accepted", div_reject, 0);
    write_div(0);
    check("R4 write of zero refused while both active", div_reject, 1);
    tx_active = 0;
    cyc(1);
    write_div(2);
    check("R4 write accepted with one direction", div_reject, 0);
    high_len(n);
    check("R4 new divider applied", n, 2);

    cur_req = "R3";
    write_div(0);
    cyc(2);
    count_ones_bclk(30, n);
    check("R3 divider zero stops bclk", n, 0);
    cyc(1);
    write_div(2);

    cur_req = "R5";
    fmt = 2'd0; period = 8'd3; slen_lo = 4'd0; slen_ext = '0; fsync_local = 1;
    start_gap(n);
    check("R5 frame gap period=3 div=2", n, 32);
    cur_req = "R12";
    wait_start();
    check("R12 sync active with strobe", fsync_o, 1);
    @(negedge clk);
    check("R12 strobe single cycle", frame_start, 0);

    cur_req = "R7";
    slen_lo = 4'd2;
    active_len(1'b1, n);
    check("R7 pulse length slen=2", n, 12);
    period = 8'd9; slen_lo = 4'd0; slen_ext = 2'd1;
    active_len(1'b1, n);
    check("R7 pulse length with extension part", n, 68);

    cur_req = "R6";
    slen_ext = '0; slen_lo = 4'd1; auto_period = 1; frame_bits = 10'd12;
    start_gap(n);
    check("R6 auto frame of 12 bits", n, 48);
    auto_period = 0; period = 8'd3;

    cur_req = "R8";
    fmt = 2'd1; slen_lo = 4'd3;
    active_len(1'b0, n);
    check("R8 I2S active low length", n, 16);
    @(negedge clk);
    check("R8 I2S idle level high", fsync_o, 1);
    fmt = 2'd3; slen_lo = 4'd0;
    wait_start(); wait_start();
    repeat (6) @(negedge clk);
    check("R8 format 3 idle low", fsync_o, 0);

    cur_req = "R9";
    fmt = 2'd2; slen_lo = 4'd5;
    active_len(1'b1, n);
    check("R9 DSP-A one-bit pulse", n, 4);
    start_gap(n);
    check("R9 DSP-A frame gap", n, 32);

    cur_req = "R10";
    cyc(1);
    fmt = 2'd0; fsync_local = 0; ext_fsync = 0;
    cyc(6);
    begin
      int k = 0;
      fork
        begin
          repeat (3) begin ext_fsync = 1; cyc(6); ext_fsync = 0; cyc(6); end
          cyc(4);
        end
        begin
          repeat (42) begin @(negedge clk); if (frame_start) k++; end
        end
      join
      check("R10 rising-edge strobes", k, 3);
      check("R10 fsync_o not driven", fsync_o, 0);
      check("R10 fsync_oe low", fsync_oe, 0);
      fmt = 2'd1; ext_fsync = 1;
      cyc(6);
      k = 0;
      fork
        begin
          repeat (2) begin ext_fsync = 0; cyc(6); ext_fsync = 1; cyc(6); end
          cyc(4);
        end
        begin
          repeat (28) begin @(negedge clk); if (frame_start) k++; end
        end
      join
      check("R10 I2S falling-edge strobes", k, 2);
    end

    cur_req = "R11";
    ext_fsync = 0; fmt = 2'd0; period = 8'd3; slen_lo = 4'd0;
    bclk_local = 0; eb_on = 1; fsync_local = 1;
    start_gap(n);
    check("R11 frame gap on external bclk", n, 80);
    check("R11 bclk_o not driven", bclk_o, 0);
    check("R11 bclk_oe low", bclk_oe, 0);
    period = 8'd1;
    start_gap(n);
    check("R11 shorter frame on external bclk", n, 40);

    cyc(5);
    finish_run();
  end
endmodule